// File: doc/BRIEF.md
# Mailbox Message Handshake Responder

This block sits on the companion side of four shared byte-wide mailbox registers and runs one complete message exchange with a host at a time. It watches the host control register for a start-of-exchange command and acknowledges it. It then takes in a two-byte request length and the request payload one byte at a time. Each byte uses an echo handshake, and the low bit of the command acts as a one-bit alternating sequence number. After that it hands back a two-byte response length and the response payload through the same kind of handshake, using a separate read command value.

The shared registers are reached through a simple single-access port: one read or one write per cycle, with a register select and read data that returns in the same cycle. Received payload bytes leave on a valid/ready byte stream. The response length bytes, followed by the response payload, arrive on a second valid/ready stream. The block has no timeout and no retry. While no exchange is running, it samples host control only once every `poll_gap + 1` cycles. Once an exchange has started, it samples host control every cycle.

Top module: `mbox_responder`

## Requirements
- R1: While reset is held, and right after it, `req_valid` and `rsp_ready` are low, no register write takes place, and companion control keeps its reset value.
- R2: While idle, host control (select 2) is read exactly once in every `poll_gap + 1` cycles, for `poll_gap` of 1 or more. Any host control value other than 0xF1 is ignored: nothing is written.
- R3: When host control reads 0xF1 while idle, 0xF1 is written to companion control (select 0). From then on, host control is read every cycle. The select encoding is 0 companion control, 1 companion data, 2 host control, 3 host data.
- R4: In the request stage the expected command starts at 0x02 after a reset-sync and flips bit 0 after every byte. When host control matches, host data (select 3) is read, and the matching value is then written to companion control as the acknowledgment. A host control value with the wrong bit 0 causes no acknowledgment and no output byte.
- R5: The first two request bytes form the length, high byte first. Exactly that many following bytes appear on the request stream, in order, and lengths above 255 are handled.
- R6: A request byte offered on `req_valid` keeps its data until `req_ready` is high. Its acknowledgment is not written before the byte is accepted.
- R7: On entry to the response stage the sequence bit is cleared, so the first expected command is 0x06, with bit 0 flipping after each byte. For each byte, one byte is taken from the response stream, written to companion data (select 1), and only then is the command echoed to companion control.
- R8: The first two response-stream bytes are sent as the response length, high byte first, followed by exactly that many payload bytes. The block then returns to idle polling.
- R9: A request length of zero skips the payload, and the next expected command is 0x06.
- R10: A response length of zero ends the exchange right after the two length bytes.
- R11: The block never reads and writes the shared registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_gap | input | GAP_W | Idle cycles between host control samples, minus one |
| reg_sel | output | 2 | Register select: 0 companion control, 1 companion data, 2 host control, 3 host data |
| reg_rd_en | output | 1 | Read strobe for the selected register |
| reg_wr_en | output | 1 | Write strobe for the selected register |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data of the selected register, same cycle |
| req_valid | output | 1 | Request payload byte available |
| req_ready | input | 1 | Request byte accepted |
| req_data | output | 8 | Request payload byte |
| rsp_valid | input | 1 | Response byte available |
| rsp_ready | output | 1 | Response byte taken |
| rsp_data | input | 8 | Response length bytes, then payload bytes |

## Verification
The assertions assume that `poll_gap` is never zero, and that the read data belongs to the register selected in the same cycle. They also assume the host moves to a new command value only after it has seen the previous echo. The bench models the host as a set of tasks that always wait for the acknowledgment before changing host control. It draws `poll_gap` from 1 to 7, and it drives the stream handshakes with random stalls from a fixed seed. A few directed steps break the host discipline on purpose, with a wrong sequence bit and a non-sync idle value, and these are checked only at the ports.

// File: rtl/mbx_pkg.sv
// Shared definitions for the mailbox handshake responder.
// Assumes a four-register mailbox with byte-wide registers.
package mbx_pkg;

    // Register select encoding on the mailbox access port.
    localparam logic [1:0] SEL_CO_CTRL = 2'd0;
    localparam logic [1:0] SEL_CO_DATA = 2'd1;
    localparam logic [1:0] SEL_HO_CTRL = 2'd2;
    localparam logic [1:0] SEL_HO_DATA = 2'd3;

    // Command values seen in host control.
    localparam logic [7:0] CMD_SYNC  = 8'hF1;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h06;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC_ACK,
        ST_W_POLL,
        ST_W_DATA,
        ST_W_PUSH,
        ST_W_ACK,
        ST_R_POLL,
        ST_R_FETCH,
        ST_R_DATA,
        ST_R_ACK
    } mbx_state_e;

    typedef enum logic [1:0] {
        PH_REQ_LEN,
        PH_REQ_BODY,
        PH_RSP_LEN,
        PH_RSP_BODY
    } mbx_phase_e;

endpackage

// File: rtl/mbx_poll_timer.sv
// Idle poll divider: raises tick once every gap+1 enabled cycles.
// Assumes gap is at least 1 and changes only while disabled or between ticks.
module mbx_poll_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [GAP_W-1:0] gap,
    output logic             tick
);
    logic [GAP_W-1:0] cnt;

    assign tick = en && (cnt >= gap);

    // Count enabled cycles and wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt >= gap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: with a non-zero gap two ticks never come back to back.
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && gap != '0) |=> !tick);

endmodule

// File: rtl/mbx_len_counter.sv
// Remaining-byte counter: loaded high byte then low byte, counted down per byte.
// Assumes LEN_W is between 9 and 16 and that dec is never raised at zero.
module mbx_len_counter #(
    parameter int LEN_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_hi,
    input  logic       load_lo,
    input  logic [7:0] data,
    input  logic       dec,
    output logic       is_zero,
    output logic       is_one
);
    localparam int HI_W = LEN_W - 8;

    logic [LEN_W-1:0] cnt;

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == LEN_W'(1));

    // Load the length bytes and step down once per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_hi) begin
            cnt[LEN_W-1:8] <= data[HI_W-1:0];
        end else if (load_lo) begin
            cnt[7:0] <= data;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R5: a byte is never counted against an empty length.
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !is_zero);

endmodule

// File: rtl/mbx_ctrl.sv
// Handshake sequencer: runs sync, request length/body and response
// length/body stages over the mailbox access port.
// Assumes read data is valid in the same cycle as the read strobe.
module mbx_ctrl
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       poll_tick,
    output logic       idle,
    output logic [1:0] reg_sel,
    output logic       reg_rd_en,
    output logic       reg_wr_en,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata,
    output logic       req_valid,
    input  logic       req_ready,
    output logic [7:0] req_data,
    input  logic       rsp_valid,
    output logic       rsp_ready,
    input  logic [7:0] rsp_data,
    output logic       cnt_load_hi,
    output logic       cnt_load_lo,
    output logic [7:0] cnt_data,
    output logic       cnt_dec,
    input  logic       cnt_zero,
    input  logic       cnt_one
);
    mbx_state_e state;
    mbx_phase_e phase;
    logic       seq;
    logic       first;
    logic [7:0] byte_q;
    logic [7:0] w_cmd;
    logic [7:0] r_cmd;

    assign w_cmd    = CMD_WRITE | {7'b0, seq};
    assign r_cmd    = CMD_READ  | {7'b0, seq};
    assign idle     = (state == ST_IDLE);
    assign req_data = byte_q;
    assign cnt_data = (state == ST_R_FETCH) ? rsp_data : reg_rdata;

    // Decode the mailbox access and stream strobes from the current state.
    always_comb begin
        reg_rd_en   = 1'b0;
        reg_wr_en   = 1'b0;
        reg_sel     = SEL_HO_CTRL;
        reg_wdata   = 8'h00;
        req_valid   = 1'b0;
        rsp_ready   = 1'b0;
        cnt_load_hi = 1'b0;
        cnt_load_lo = 1'b0;
        cnt_dec     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                reg_rd_en = poll_tick;
            end
            ST_SYNC_ACK: begin
                reg_wr_en = 1'b1;
                reg_sel   = SEL_CO_CTRL;
                reg_wdata = CMD_SYNC;
            end
            ST_W_POLL: begin
                reg_rd_en = 1'b1;
            end
            ST_W_DATA: begin
                reg_rd_en   = 1'b1;
                reg_sel     = SEL_HO_DATA;
                cnt_load_hi = (phase == PH_REQ_LEN) && first;
                cnt_load_lo = (phase == PH_REQ_LEN) && !first;
            end
            ST_W_PUSH: begin
                req_valid = 1'b1;
            end
            ST_W_ACK: begin
                reg_wr_en = 1'b1;
                reg_sel   = SEL_CO_CTRL;
                reg_wdata = w_cmd;
                cnt_dec   = (phase == PH_REQ_BODY);
            end
            ST_R_POLL: begin
                reg_rd_en = 1'b1;
            end
            ST_R_FETCH: begin
                rsp_ready   = 1'b1;
                cnt_load_hi = rsp_valid && (phase == PH_RSP_LEN) && first;
                cnt_load_lo = rsp_valid && (phase == PH_RSP_LEN) && !first;
            end
            ST_R_DATA: begin
                reg_wr_en = 1'b1;
                reg_sel   = SEL_CO_DATA;
                reg_wdata = byte_q;
            end
            ST_R_ACK: begin
                reg_wr_en = 1'b1;
                reg_sel   = SEL_CO_CTRL;
                reg_wdata = r_cmd;
                cnt_dec   = (phase == PH_RSP_BODY);
            end
            default: ;
        endcase
    end

    // Advance the handshake sequence, stage and sequence bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            phase  <= PH_REQ_LEN;
            seq    <= 1'b0;
            first  <= 1'b1;
            byte_q <= 8'h00;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (poll_tick && reg_rdata == CMD_SYNC) begin
                        state <= ST_SYNC_ACK;
                    end
                end
                ST_SYNC_ACK: begin
                    seq   <= 1'b0;
                    first <= 1'b1;
                    phase <= PH_REQ_LEN;
                    state <= ST_W_POLL;
                end
                ST_W_POLL: begin
                    if (reg_rdata == w_cmd) begin
                        state <= ST_W_DATA;
                    end
                end
                ST_W_DATA: begin
                    byte_q <= reg_rdata;
                    state  <= (phase == PH_REQ_BODY) ? ST_W_PUSH : ST_W_ACK;
                end
                ST_W_PUSH: begin
                    if (req_ready) begin
                        state <= ST_W_ACK;
                    end
                end
                ST_W_ACK: begin
                    seq <= ~seq;
                    if (phase == PH_REQ_LEN && first) begin
                        first <= 1'b0;
                        state <= ST_W_POLL;
                    end else if ((phase == PH_REQ_LEN && cnt_zero) ||
                                 (phase == PH_REQ_BODY && cnt_one)) begin
                        seq   <= 1'b0;
                        first <= 1'b1;
                        phase <= PH_RSP_LEN;
                        state <= ST_R_POLL;
                    end else begin
                        phase <= PH_REQ_BODY;
                        state <= ST_W_POLL;
                    end
                end
                ST_R_POLL: begin
                    if (reg_rdata == r_cmd) begin
                        state <= ST_R_FETCH;
                    end
                end
                ST_R_FETCH: begin
                    if (rsp_valid) begin
                        byte_q <= rsp_data;
                        state  <= ST_R_DATA;
                    end
                end
                ST_R_DATA: begin
                    state <= ST_R_ACK;
                end
                ST_R_ACK: begin
                    seq <= ~seq;
                    if (phase == PH_RSP_LEN && first) begin
                        first <= 1'b0;
                        state <= ST_R_POLL;
                    end else if ((phase == PH_RSP_LEN && cnt_zero) ||
                                 (phase == PH_RSP_BODY && cnt_one)) begin
                        state <= ST_IDLE;
                    end else begin
                        phase <= PH_RSP_BODY;
                        state <= ST_R_POLL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the sync acknowledgment follows an idle read of the sync value.
    a_r3_sync_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC_ACK) |-> ($past(reg_rd_en) && $past(reg_rdata) == CMD_SYNC));

    // R4: host data is read only after host control matched the write command.
    a_r4_data_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_W_DATA) |-> ($past(reg_rdata) == $past(w_cmd)));

    // R6: an offered request byte holds until it is accepted.
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data)));

    // R7: a response byte is fetched only after a matching read command.
    a_r7_fetch_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_R_FETCH && $past(state) == ST_R_POLL) |-> ($past(reg_rdata) == $past(r_cmd)));

    // R7: the read echo always follows the companion data write.
    a_r7_echo_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_R_ACK) |-> ($past(reg_wr_en) && $past(reg_sel) == SEL_CO_DATA));

endmodule

// File: rtl/mbox_responder.sv
// Top of the mailbox handshake responder: ties the sequencer, the idle poll
// divider and the length counter together.
// Assumes poll_gap >= 1 and a same-cycle mailbox read port.
module mbox_responder #(
    parameter int GAP_W = 16,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GAP_W-1:0] poll_gap,
    output logic [1:0]       reg_sel,
    output logic             reg_rd_en,
    output logic             reg_wr_en,
    output logic [7:0]       reg_wdata,
    input  logic [7:0]       reg_rdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [7:0]       req_data,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [7:0]       rsp_data
);
    logic       idle;
    logic       poll_tick;
    logic       cnt_load_hi;
    logic       cnt_load_lo;
    logic [7:0] cnt_data;
    logic       cnt_dec;
    logic       cnt_zero;
    logic       cnt_one;

    mbx_poll_timer #(.GAP_W(GAP_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (idle),
        .gap   (poll_gap),
        .tick  (poll_tick)
    );

    mbx_len_counter #(.LEN_W(LEN_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (cnt_load_hi),
        .load_lo (cnt_load_lo),
        .data    (cnt_data),
        .dec     (cnt_dec),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    mbx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_tick   (poll_tick),
        .idle        (idle),
        .reg_sel     (reg_sel),
        .reg_rd_en   (reg_rd_en),
        .reg_wr_en   (reg_wr_en),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_data    (req_data),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_data    (rsp_data),
        .cnt_load_hi (cnt_load_hi),
        .cnt_load_lo (cnt_load_lo),
        .cnt_data    (cnt_data),
        .cnt_dec     (cnt_dec),
        .cnt_zero    (cnt_zero),
        .cnt_one     (cnt_one)
    );

    // R11: the mailbox port carries one access per cycle.
    a_r11_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en && reg_wr_en));

endmodule

// File: tb/sim_mbox_responder.sv
// Bench: models the host side of the mailbox and both byte streams.
module sim_mbox_responder;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [GAP_W-1:0] poll_gap;
    logic [1:0]       reg_sel;
    logic             reg_rd_en, reg_wr_en;
    logic [7:0]       reg_wdata, reg_rdata;
    logic             req_valid, req_ready;
    logic [7:0]       req_data;
    logic             rsp_valid, rsp_ready;
    logic [7:0]       rsp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_responder #(.GAP_W(GAP_W)) u0 (.*);

    // Mailbox register model
    logic [7:0] r_cc, r_cd, r_hc, r_hd;
    always_comb begin
        case (reg_sel)
            2'd0:    reg_rdata = r_cc;
            2'd1:    reg_rdata = r_cd;
            2'd2:    reg_rdata = r_hc;
            default: reg_rdata = r_hd;
        endcase
    end
    always @(posedge clk) begin
        if (!rst_n) begin
            r_cc <= 8'h00;
            r_cd <= 8'h00;
        end else if (reg_wr_en) begin
            if (reg_sel == 2'd0) r_cc <= reg_wdata;
            else if (reg_sel == 2'd1) r_cd <= reg_wdata;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int hc_reads = 0, wr_count = 0, dual = 0, hold_err = 0;
    bit stall = 0, prev_stall = 0;
    logic [7:0] prev_data;
    logic [7:0] got_q[$], rsp_src[$], tx_q[$], body_q[$];
    logic wseq, rseq;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pick_byte();
        return 8'($urandom);
    endfunction

    // Stream models and port monitors, all at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_stall = 0;
            req_ready  = 0;
            rsp_valid  = 0;
            rsp_data   = 0;
        end else begin
            if (prev_stall && !(req_valid && req_data == prev_data)) hold_err++;
            req_ready = stall ? 1'b0 : (($urandom % 4) != 0);
            if (req_valid && req_ready) got_q.push_back(req_data);
            prev_stall = req_valid && !req_ready;
            prev_data  = req_data;
            if (rsp_src.size() > 0 && ($urandom % 3) != 0) begin
                rsp_valid = 1;
                rsp_data  = rsp_src[0];
                if (rsp_ready) void'(rsp_src.pop_front());
            end else begin
                rsp_valid = 0;
            end
            if (reg_rd_en && reg_sel == 2'd2) hc_reads++;
            if (reg_wr_en) wr_count++;
            if (reg_rd_en && reg_wr_en) dual++;
        end
    end

    task automatic wait_cc(input logic [7:0] v, input string tag);
        int n = 0;
        while (r_cc !== v && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(r_cc === v, tag, "echo in companion control", r_cc, v);
    endtask

    task automatic host_sync();
        @(negedge clk);
        r_hc = 8'hF1;
        wseq = 0;
        wait_cc(8'hF1, "R3");
    endtask

    task automatic host_write(input logic [7:0] b, input string tag);
        @(negedge clk);
        r_hd = b;
        r_hc = 8'h02 | {7'b0, wseq};
        wait_cc(8'h02 | {7'b0, wseq}, tag);
        wseq = ~wseq;
    endtask

    task automatic host_read(output logic [7:0] b, input string tag);
        @(negedge clk);
        r_hc = 8'h06 | {7'b0, rseq};
        wait_cc(8'h06 | {7'b0, rseq}, tag);
        b = r_cd;
        rseq = ~rseq;
    endtask

    // One full exchange; probe adds the directed poll, ignore and stall steps.
    task automatic run_exchange(input bit probe, input string tag);
        logic [7:0] b, prev;
        int snap;
        got_q.delete();
        rsp_src.delete();
        rsp_src.push_back(8'(body_q.size() >> 8));
        rsp_src.push_back(8'(body_q.size()));
        foreach (body_q[i]) rsp_src.push_back(body_q[i]);
        host_sync();
        if (probe) begin
            snap = hc_reads;
            repeat (6) @(negedge clk);
            check(hc_reads - snap == 6, "R3", "reads every cycle after sync", hc_reads - snap, 6);
            r_hd = 8'hAA;
            r_hc = 8'h03;
            repeat (15) @(negedge clk);
            check(r_cc == 8'hF1, "R4", "wrong sequence bit not acked", r_cc, 8'hF1);
            check(got_q.size() == 0 && !req_valid, "R4", "wrong sequence bit no byte", got_q.size(), 0);
        end
        host_write(8'(tx_q.size() >> 8), "R5");
        host_write(8'(tx_q.size()), "R5");
        for (int i = 0; i < tx_q.size(); i++) begin
            if (probe && i == 0) begin
                @(negedge clk);
                stall = 1;
                prev = r_cc;
                r_hd = tx_q[0];
                r_hc = 8'h02 | {7'b0, wseq};
                repeat (12) @(negedge clk);
                check(r_cc == prev, "R6", "no ack while stalled", r_cc, prev);
                check(req_valid && req_data == tx_q[0], "R6", "byte offered", req_data, tx_q[0]);
                stall = 0;
                wait_cc(8'h02 | {7'b0, wseq}, "R6");
                wseq = ~wseq;
            end else begin
                host_write(tx_q[i], "R4");
            end
        end
        rseq = 0;
        host_read(b, "R7");
        check(b == 8'(body_q.size() >> 8), "R8", "length high byte", b, body_q.size() >> 8);
        host_read(b, "R7");
        check(b == 8'(body_q.size()), "R8", "length low byte", b, body_q.size() & 255);
        foreach (body_q[i]) begin
            host_read(b, "R7");
            check(b == body_q[i], "R8", "response byte", b, body_q[i]);
        end
        repeat (5) @(negedge clk);
        check(got_q.size() == tx_q.size(), {tag, " R5"}, "request byte count", got_q.size(), tx_q.size());
        foreach (tx_q[i]) begin
            if (i < got_q.size() && got_q[i] != tx_q[i])
                check(0, "R5", "request byte", got_q[i], tx_q[i]);
        end
        check(rsp_src.size() == 0, "R8", "response stream drained", rsp_src.size(), 0);
        snap = hc_reads;
        repeat (4 * (int'(poll_gap) + 1)) @(negedge clk);
        check(hc_reads - snap == 4, "R8", "back to idle cadence", hc_reads - snap, 4);
    endtask

    task automatic fill(input int nreq, input int nrsp);
        tx_q.delete();
        body_q.delete();
        for (int i = 0; i < nreq; i++) tx_q.push_back(pick_byte());
        for (int i = 0; i < nrsp; i++) body_q.push_back(pick_byte());
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int snap;
        void'($urandom(32'd2024));
        rst_n = 0;
        poll_gap = 3;
        r_hc = 8'h00;
        r_hd = 8'h00;
        repeat (3) @(negedge clk);
        check(!req_valid && !rsp_ready, "R1", "streams idle in reset", req_valid, 0);
        check(!reg_wr_en, "R1", "no write in reset", reg_wr_en, 0);
        rst_n = 1;
        @(negedge clk);
        check(r_cc == 8'h00, "R1", "companion control after reset", r_cc, 0);

        snap = hc_reads;
        repeat (40) @(negedge clk);
        check(hc_reads - snap == 10, "R2", "idle poll cadence gap 3", hc_reads - snap, 10);

        r_hc = 8'h02;
        snap = wr_count;
        repeat (20) @(negedge clk);
        check(wr_count == snap && r_cc == 8'h00, "R2", "non-sync idle value ignored", wr_count - snap, 0);

        poll_gap = 7;
        fill(3, 2);
        run_exchange(1, "directed");
        fill(0, 4);
        run_exchange(0, "R9 zero request");
        fill(2, 0);
        run_exchange(0, "R10 zero response");
        fill(0, 0);
        run_exchange(0, "R9 R10 both zero");
        poll_gap = 2;
        fill(300, 3);
        run_exchange(0, "R5 long request");
        for (int k = 0; k < 6; k++) begin
            poll_gap = GAP_W'(1 + $urandom % 7);
            fill(int'($urandom % 10), int'($urandom % 10));
            run_exchange(0, "random");
        end

        check(dual == 0, "R11", "read and write in one cycle", dual, 0);
        check(hold_err == 0, "R6", "request data held while stalled", hold_err, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule